// File: doc/BRIEF.md
# General-Purpose Register File with Width-Aware Writes

This block holds the integer registers of a 64-bit core: sixteen registers read through two combinational ports and written through one strobed port. Every write states its destination size (1, 2, 4 or 8 bytes) and a write operation. The block shapes the written value before storing it. Narrow writes of 1 or 2 bytes merge into the old contents. A 4-byte write clears the upper half. An 8-byte write replaces the whole register.

The same port also carries widening moves, which zero- or sign-extend a narrower source field to the destination size. It carries an accumulator convert, which sign-extends the low word of register 0 in place. It also carries stack push and pop, which step register 4 by one 8-byte slot and present the memory address of the access. Memory, decoding and flags live elsewhere. The block only supplies the stack address and the updated pointer. A read of the register being written in the same cycle returns the value that is about to be stored.

Top module: `gpr_file`

## Requirements
- R1: While rst_ni is low, every register is cleared to zero asynchronously; all sixteen read back as zero after reset.
- R2: A plain write (wr_op_i=0) of size code 3 (8 bytes; size codes 0,1,2,3 mean 1,2,4,8 bytes) stores all 64 bits of wr_data_i at the next rising clock edge.
- R3: A plain write of size code 0 or 1 replaces only bits 7:0 or 15:0 of the register and keeps every higher bit.
- R4: A plain write of size code 2 stores bits 31:0 of wr_data_i and forces bits 63:32 to zero.
- R5: A zero-extending write (wr_op_i=1) takes the source field of width wr_src_i (same size coding), zero-extends it, and then stores it under the destination-size rules of R2 to R4. For example, byte to word keeps bits 63:16.
- R6: A sign-extending write (wr_op_i=2) does the same with sign extension, including 4 bytes to 8 bytes. A source width not narrower than the destination acts as a plain write.
- R7: A convert (wr_op_i=3) replaces register 0 with bits 31:0 of register 0 sign-extended to 64 bits; wr_addr_i and wr_data_i are ignored.
- R8: A push (wr_op_i=4) drives stk_addr_o and stk_sp_o with the pointer in register 4 minus 8 in the same cycle, and stores that value in register 4.
- R9: A pop (wr_op_i=5) drives stk_addr_o with the current register 4 and stk_sp_o with that value plus 8, and stores the incremented value in register 4.
- R10: A read port whose address matches the register being written in that cycle returns the new shaped value (write-first bypass).
- R11: With wr_en_i low, or with wr_op_i 6 or 7, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 64 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 64 | Read port B data |
| wr_en_i | input | 1 | Write strobe |
| wr_op_i | input | 3 | 0 plain, 1 zero-extend, 2 sign-extend, 3 convert, 4 push, 5 pop |
| wr_addr_i | input | 4 | Destination register for ops 0 to 2 |
| wr_data_i | input | 64 | Write value |
| wr_size_i | input | 2 | Destination size code |
| wr_src_i | input | 2 | Source size code for ops 1 and 2 |
| stk_addr_o | output | 64 | Stack access address during push or pop, else current pointer |
| stk_sp_o | output | 64 | Pointer value after the current operation |

## Verification
A wrong merge or extension stays hidden until the register is read, and then it shows as wrong upper bytes. The bench therefore reads back each destination in the cycle right after the write edge. It also reads the destination through the bypass in the write cycle itself, so a bypass fault appears on the same cycle. A stack pointer that is off by a slot appears on stk_addr_o at the very next push or pop. Because the pointer steps by a fixed amount, a push followed by a pop that does not return it to its start value exposes any drift.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int XLEN = 64;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_ZEXT  = 3'd1,
    OP_SEXT  = 3'd2,
    OP_CVT   = 3'd3,
    OP_PUSH  = 3'd4,
    OP_POP   = 3'd5
  } gpr_op_e;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } gpr_size_e;
endpackage

// File: rtl/gpr_shaper.sv
module gpr_shaper
  import gpr_pkg::*;
(
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] data_i,
  input  gpr_size_e       dst_i,
  input  gpr_size_e       src_i,
  input  gpr_op_e         op_i,
  output logic [XLEN-1:0] val_o
);
  logic [XLEN-1:0] ext;
  logic            sgn;

  always_comb begin
    ext = data_i;
    sgn = 1'b0;
    if (op_i == OP_ZEXT || op_i == OP_SEXT) begin
      unique case (src_i)
        SZ_B1: sgn = data_i[7];
        SZ_B2: sgn = data_i[15];
        SZ_B4: sgn = data_i[31];
        default: sgn = data_i[63];
      endcase
      if (op_i == OP_ZEXT) sgn = 1'b0;
      unique case (src_i)
        SZ_B1: ext = {{56{sgn}}, data_i[7:0]};
        SZ_B2: ext = {{48{sgn}}, data_i[15:0]};
        SZ_B4: ext = {{32{sgn}}, data_i[31:0]};
        default: ext = data_i;
      endcase
    end
  end

  // narrow writes merge, 4-byte clears upper half
  always_comb begin
    unique case (dst_i)
      SZ_B1: val_o = {old_i[63:8], ext[7:0]};
      SZ_B2: val_o = {old_i[63:16], ext[15:0]};
      SZ_B4: val_o = {32'b0, ext[31:0]};
      default: val_o = ext;
    endcase
  end
endmodule

// File: rtl/gpr_stack.sv
module gpr_stack
  import gpr_pkg::*;
#(
  parameter int SLOT = 8
) (
  input  logic [XLEN-1:0] sp_i,
  input  logic            push_i,
  input  logic            pop_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] sp_next_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(SLOT);
  logic [XLEN-1:0] dec;

  assign dec = sp_i - STEP;

  always_comb begin
    addr_o    = sp_i;
    sp_next_o = sp_i;
    if (push_i) begin
      addr_o    = dec;
      sp_next_o = dec;
    end else if (pop_i) begin
      sp_next_o = sp_i + STEP;
    end
  end
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
  import gpr_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][XLEN-1:0] regs_i,
  input  logic [AW-1:0]             addr_i,
  input  logic                      wr_hit_en_i,
  input  logic [AW-1:0]             wr_idx_i,
  input  logic [XLEN-1:0]           wr_val_i,
  output logic [XLEN-1:0]           data_o
);
  assign data_o = (wr_hit_en_i && wr_idx_i == addr_i) ? wr_val_i : regs_i[addr_i];
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int SP_IDX  = 4,
  parameter int ACC_IDX = 0,
  parameter int SLOT    = 8,
  localparam int AW     = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   rd_a_addr_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [AW-1:0]   rd_b_addr_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_op_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [1:0]      wr_size_i,
  input  logic [1:0]      wr_src_i,
  output logic [XLEN-1:0] stk_addr_o,
  output logic [XLEN-1:0] stk_sp_o
);
  localparam int NRD = 2;

  logic [NREG-1:0][XLEN-1:0] regs_q;
  gpr_op_e         op;
  logic [XLEN-1:0] shaped, sp_next, acc_cvt;
  logic            we;
  logic [AW-1:0]   w_idx;
  logic [XLEN-1:0] w_val;
  logic            ok_q;

  assign op = gpr_op_e'(wr_op_i);

  gpr_shaper u_shape (
    .old_i  (regs_q[wr_addr_i]),
    .data_i (wr_data_i),
    .dst_i  (gpr_size_e'(wr_size_i)),
    .src_i  (gpr_size_e'(wr_src_i)),
    .op_i   (op),
    .val_o  (shaped)
  );

  gpr_stack #(.SLOT(SLOT)) u_stack (
    .sp_i      (regs_q[SP_IDX]),
    .push_i    (wr_en_i && op == OP_PUSH),
    .pop_i     (wr_en_i && op == OP_POP),
    .addr_o    (stk_addr_o),
    .sp_next_o (sp_next)
  );
  assign stk_sp_o = sp_next;

  assign acc_cvt = {{32{regs_q[ACC_IDX][31]}}, regs_q[ACC_IDX][31:0]};

  always_comb begin
    we    = wr_en_i;
    w_idx = wr_addr_i;
    w_val = shaped;
    unique case (op)
      OP_PLAIN, OP_ZEXT, OP_SEXT: ;
      OP_CVT: begin
        w_idx = AW'(ACC_IDX);
        w_val = acc_cvt;
      end
      OP_PUSH, OP_POP: begin
        w_idx = AW'(SP_IDX);
        w_val = sp_next;
      end
      default: we = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[g] <= '0;
      else if (we && w_idx == AW'(g))    regs_q[g] <= w_val;
    end
  end

  logic [NRD-1:0][AW-1:0]   rd_addr;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  assign rd_addr = {rd_b_addr_i, rd_a_addr_i};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_rd_port #(.NREG(NREG)) u_rd (
      .regs_i      (regs_q),
      .addr_i      (rd_addr[p]),
      .wr_hit_en_i (we),
      .wr_idx_i    (w_idx),
      .wr_val_i    (w_val),
      .data_o      (rd_data[p])
    );
  end
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= 1'b1;
  end

  assert_rd_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |=> $past(rd_a_data_o) == regs_q[$past(rd_a_addr_i)]);

  assert_narrow_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && wr_en_i && op == OP_PLAIN && wr_size_i == 2'd0)
    |=> regs_q[$past(wr_addr_i)][63:8] == $past(regs_q[wr_addr_i][63:8]));

  assert_half_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && wr_en_i && op == OP_PLAIN && wr_size_i == 2'd2)
    |=> regs_q[$past(wr_addr_i)][63:32] == 32'b0);

  assert_push_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && wr_en_i && op == OP_PUSH) |=> regs_q[SP_IDX] == $past(stk_addr_o));

  assert_pop_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && wr_en_i && op == OP_POP)
    |=> regs_q[SP_IDX] - XLEN'(SLOT) == $past(stk_addr_o));

  assert_cvt_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && wr_en_i && op == OP_CVT)
    |=> regs_q[ACC_IDX][63:32] == {32{$past(regs_q[ACC_IDX][31])}});

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && !wr_en_i) |=> regs_q == $past(regs_q));
endmodule

// File: tb/sim_gpr_file.sv
`timescale 1ns/1ps
module sim_gpr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ra, rb, wa;
  logic [63:0] da, db, wd, saddr, ssp;
  logic        we;
  logic [2:0]  wop;
  logic [1:0]  wsz, wsrc;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpr_file u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_addr_i(ra), .rd_a_data_o(da),
    .rd_b_addr_i(rb), .rd_b_data_o(db),
    .wr_en_i(we), .wr_op_i(wop), .wr_addr_i(wa), .wr_data_i(wd),
    .wr_size_i(wsz), .wr_src_i(wsrc),
    .stk_addr_o(saddr), .stk_sp_o(ssp)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write with inputs applied at negedge; returns after the write edge
  task automatic wr(logic [2:0] op, logic [3:0] a, logic [63:0] d,
                    logic [1:0] sz, logic [1:0] src);
    @(negedge clk);
    we = 1'b1; wop = op; wa = a; wd = d; wsz = sz; wsrc = src;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [63:0] exp);
    ra = a; rb = a;
    #1;
    chk(req, da, exp);
    chk(req, db, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) begin
      ra = 4'(i); #1; chk("R1", da, 64'h0);
    end
  endtask

  task automatic t_full;
    wr(3'd0, 4'd3, 64'h1122334455667788, 2'd3, 2'd0);
    rd_chk("R2", 4'd3, 64'h1122334455667788);
  endtask

  task automatic t_narrow;
    wr(3'd0, 4'd3, 64'hFFFFFFFFFFFFFFAB, 2'd0, 2'd0);
    rd_chk("R3", 4'd3, 64'h11223344556677AB);
    wr(3'd0, 4'd3, 64'h000000000000CDEF, 2'd1, 2'd0);
    rd_chk("R3", 4'd3, 64'h112233445566CDEF);
  endtask

  task automatic t_half;
    wr(3'd0, 4'd3, 64'hFFFFFFFF89ABCDEF, 2'd2, 2'd0);
    rd_chk("R4", 4'd3, 64'h0000000089ABCDEF);
  endtask

  task automatic t_zext;
    wr(3'd0, 4'd5, 64'hFFFFFFFFFFFFFFFF, 2'd3, 2'd0);
    wr(3'd1, 4'd5, 64'hFFFFFFFFFFFFFF80, 2'd1, 2'd0);
    rd_chk("R5", 4'd5, 64'hFFFFFFFFFFFF0080);
    wr(3'd1, 4'd5, 64'hFFFFFFFFFFFFFF80, 2'd2, 2'd0);
    rd_chk("R5", 4'd5, 64'h0000000000000080);
    wr(3'd1, 4'd6, 64'hFFFFFFFFFFFF8001, 2'd3, 2'd1);
    rd_chk("R5", 4'd6, 64'h0000000000008001);
  endtask

  task automatic t_sext;
    wr(3'd2, 4'd7, 64'h0000000000000080, 2'd3, 2'd0);
    rd_chk("R6", 4'd7, 64'hFFFFFFFFFFFFFF80);
    wr(3'd2, 4'd7, 64'h0000000000008001, 2'd2, 2'd1);
    rd_chk("R6", 4'd7, 64'h00000000FFFF8001);
    wr(3'd2, 4'd7, 64'h0000000080000000, 2'd3, 2'd2);
    rd_chk("R6", 4'd7, 64'hFFFFFFFF80000000);
    wr(3'd0, 4'd8, 64'h123456789ABCDEF0, 2'd3, 2'd0);
    wr(3'd2, 4'd8, 64'h00000000000000F0, 2'd1, 2'd0);
    rd_chk("R6", 4'd8, 64'h123456789ABCFFF0);
    // source not narrower than destination: plain 1-byte merge
    wr(3'd2, 4'd8, 64'h0000000000000011, 2'd0, 2'd2);
    rd_chk("R6", 4'd8, 64'h123456789ABCFF11);
  endtask

  task automatic t_cvt;
    wr(3'd0, 4'd0, 64'h1234567887654321, 2'd3, 2'd0);
    wr(3'd3, 4'd9, 64'hDEADBEEFDEADBEEF, 2'd3, 2'd0);
    rd_chk("R7", 4'd0, 64'hFFFFFFFF87654321);
    rd_chk("R7", 4'd9, 64'h0);
    wr(3'd0, 4'd0, 64'hFFFFFFFF12345678, 2'd3, 2'd0);
    wr(3'd3, 4'd0, 64'h0, 2'd3, 2'd0);
    rd_chk("R7", 4'd0, 64'h0000000012345678);
  endtask

  task automatic t_stack;
    wr(3'd0, 4'd4, 64'h1000, 2'd3, 2'd0);
    @(negedge clk);
    we = 1'b1; wop = 3'd4; wa = 4'd2; ra = 4'd4; rb = 4'd2;
    #1;
    chk("R8", saddr, 64'hFF8);
    chk("R8", ssp, 64'hFF8);
    chk("R10", da, 64'hFF8);
    @(negedge clk);
    we = 1'b0;
    rd_chk("R8", 4'd4, 64'hFF8);
    rd_chk("R8", 4'd2, 64'h0);
    @(negedge clk);
    we = 1'b1; wop = 3'd5; ra = 4'd4;
    #1;
    chk("R9", saddr, 64'hFF8);
    chk("R9", ssp, 64'h1000);
    @(negedge clk);
    we = 1'b0;
    rd_chk("R9", 4'd4, 64'h1000);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    we = 1'b1; wop = 3'd0; wa = 4'd3; wd = 64'h00000000000000EE;
    wsz = 2'd0; ra = 4'd3; rb = 4'd5;
    #1;
    chk("R10", da, 64'h00000000890000EE | 64'h0000000000ABCD00);
    chk("R10", db, 64'h0000000000000080);
    @(negedge clk);
    we = 1'b0;
    rd_chk("R10", 4'd3, 64'h0000000089ABCDEE);
  endtask

  task automatic t_idle;
    @(negedge clk);
    we = 1'b0; wop = 3'd0; wa = 4'd3; wd = 64'h5555555555555555; wsz = 2'd3;
    @(negedge clk);
    rd_chk("R11", 4'd3, 64'h0000000089ABCDEE);
    wr(3'd6, 4'd3, 64'h5555555555555555, 2'd3, 2'd0);
    rd_chk("R11", 4'd3, 64'h0000000089ABCDEE);
    wr(3'd7, 4'd4, 64'h5555555555555555, 2'd3, 2'd0);
    rd_chk("R11", 4'd4, 64'h1000);
  endtask

  initial begin
    we = 1'b0; wop = '0; wa = '0; wd = '0; wsz = '0; wsrc = '0; ra = '0; rb = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_narrow();
    t_half();
    t_zext();
    t_sext();
    t_cvt();
    t_stack();
    t_bypass();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule